// File: doc/BRIEF.md
# Per-CPU Masked Level Interrupt Controller

The controller collects level-sensitive interrupt sources, grouped into 32-bit words, and routes them to one active-high interrupt line per CPU. Each CPU owns a private bank of mask words. A set mask bit blocks its source from that CPU only, so one source can be enabled on one CPU and blocked on another. A CPU's line is raised when at least one source is both active and unmasked in any word of its bank.

Software reaches the banks through a plain 32-bit register port with a read strobe, a write strobe, an address and write data. Inside a bank there are four register groups, each one word per source word. The live-status group comes first, then the mask readback group, then the write-one-to-set group, then the write-one-to-clear group. The group index is scaled by the configured word count. A CPU index field just above the bank's offset range selects the bank. Software blocks or enables individual sources by writing ones, so it never needs a read-modify-write sequence.

Top module: `cpu_mask_intc`

## Requirements
- R1: While and after reset, every mask bit of every bank is 1, every CPU line is 0 and the read data is 0.
- R2: Within a bank, group g (0 status, 1 mask readback, 2 mask set, 3 mask clear) for word w sits at byte offset (g*NUM_WORDS + w)*4. The bank is chosen by the CPU index at address bits starting at OFS_W = clog2(16*NUM_WORDS).
- R3: A write to a mask-set register sets the mask bits where the data has ones and leaves the other bits unchanged.
- R4: A write to a mask-clear register clears the mask bits where the data has ones and leaves the other bits unchanged.
- R5: A status read returns the live source levels of that word, and reading does not clear them.
- R6: A mask readback read returns the current mask word of the addressed bank. Reads of the mask-set and mask-clear registers return 0.
- R7: Writes to status or mask readback registers change no mask bit.
- R8: cpuIrq[c] is registered: one clock after the sources or masks change, it equals the OR over all words of (source AND NOT mask of bank c).
- R9: A mask write to one bank leaves every other bank's mask and line unchanged.
- R10: An access is out of range when the offset is at or beyond 16*NUM_WORDS, when the CPU index is NUM_CPUS or more, when any address bit above the CPU field is set, or when address bits [1:0] are nonzero. An out-of-range read returns 0, and an out-of-range write changes no state.
- R11: regRdData is loaded on the clock edge that samples regRdEn and holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqSrc | input | NUM_WORDS*32 | Level source inputs; word w is bits [32w+31:32w] |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Byte address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, registered |
| cpuIrq | output | NUM_CPUS | Per-CPU interrupt lines |

## Verification
The assertions assume that irqSrc and the register strobes are synchronous to clk and stable around its rising edge. They also assume that reads and writes arrive as single-cycle strobes with the address held in that cycle. The bench drives every input at the falling edge and samples at the following falling edge, which keeps it within those assumptions. Its random addresses cover legal offsets, offsets past the bank, a CPU index without a bank, set upper bits and misaligned low bits.

// File: rtl/cpu_mask_intc_pkg.sv
package cpu_mask_intc_pkg;
  localparam int WORD_W    = 32;
  localparam int MAX_WORDS = 8;
  localparam int MAX_CPUS  = 16;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic       wrSet;
    logic       wrClr;
    logic       rdEn;
    logic       rdStatus;
    logic       rdMask;
    logic [3:0] cpu;
    logic [2:0] word;
  } ctrlStrobe_t;
endpackage

// File: rtl/cpu_mask_intc_ctrl.sv
module cpu_mask_intc_ctrl
  import cpu_mask_intc_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int NUM_CPUS  = 2,
  parameter int ADDR_W    = 12
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobe_t       strobe
);
  localparam int OFS_W = $clog2(16 * NUM_WORDS);
  localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;

  int   idxI;
  int   grpI;
  int   wrdI;
  logic groupHit;
  logic cpuOk;
  logic upperHit;
  logic aligned;
  logic legal;
  logic [CPU_W-1:0] cpuField;

  // Group-major layout: group index is offset / NUM_WORDS
  always_comb begin
    idxI     = int'(regAddr[OFS_W-1:2]);
    grpI     = 0;
    wrdI     = 0;
    groupHit = 1'b0;
    for (int g = 0; g < 4; g++) begin
      if (idxI >= g * NUM_WORDS && idxI < (g + 1) * NUM_WORDS) begin
        grpI     = g;
        wrdI     = idxI - g * NUM_WORDS;
        groupHit = 1'b1;
      end
    end
  end

  assign cpuField = regAddr[OFS_W +: CPU_W];
  assign cpuOk    = int'(cpuField) < NUM_CPUS;
  assign upperHit = (regAddr >> (OFS_W + CPU_W)) != '0;
  assign aligned  = regAddr[1:0] == 2'b00;
  assign legal    = groupHit && cpuOk && !upperHit && aligned;

  always_comb begin
    strobe          = '0;
    strobe.cpu      = 4'(cpuField);
    strobe.word     = 3'(wrdI);
    strobe.rdEn     = regRdEn;
    strobe.rdStatus = regRdEn && legal && (grpI == 0);
    strobe.rdMask   = regRdEn && legal && (grpI == 1);
    strobe.wrSet    = regWrEn && legal && (grpI == 2);
    strobe.wrClr    = regWrEn && legal && (grpI == 3);
  end
endmodule

// File: rtl/cpu_mask_intc_dp.sv
module cpu_mask_intc_dp
  import cpu_mask_intc_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int NUM_CPUS  = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 strobe,
  input  logic [NUM_WORDS*WORD_W-1:0] irqSrc,
  input  logic [WORD_W-1:0]           regWrData,
  output logic [WORD_W-1:0]           regRdData,
  output logic [NUM_CPUS-1:0]         cpuIrq
);
  localparam int BANK_W = NUM_WORDS * WORD_W;

  logic [NUM_CPUS*BANK_W-1:0] maskAll;
  logic [WORD_W-1:0]          rdMux;
  logic [WORD_W-1:0]          rdQ;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : gCpu
    for (genvar w = 0; w < NUM_WORDS; w++) begin : gWord
      logic [WORD_W-1:0] maskWord;
      logic              sel;
      assign sel = (strobe.cpu == 4'(c)) && (strobe.word == 3'(w));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          maskWord <= '1;
        end else if (sel && strobe.wrSet) begin
          maskWord <= maskWord | regWrData;
        end else if (sel && strobe.wrClr) begin
          maskWord <= maskWord & ~regWrData;
        end
      end
      assign maskAll[(c*NUM_WORDS + w)*WORD_W +: WORD_W] = maskWord;
    end

    logic pendAny;
    logic irqQ;
    assign pendAny = |(irqSrc & ~maskAll[c*BANK_W +: BANK_W]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) irqQ <= 1'b0;
      else       irqQ <= pendAny;
    end
    assign cpuIrq[c] = irqQ;
  end

  always_comb begin
    rdMux = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (strobe.rdStatus && strobe.word == 3'(w))
        rdMux = irqSrc[w*WORD_W +: WORD_W];
    end
    for (int c = 0; c < NUM_CPUS; c++) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (strobe.rdMask && strobe.cpu == 4'(c) && strobe.word == 3'(w))
          rdMux = maskAll[(c*NUM_WORDS + w)*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdQ <= '0;
    else if (strobe.rdEn) rdQ <= rdMux;
  end
  assign regRdData = rdQ;
endmodule

// File: rtl/cpu_mask_intc.sv
module cpu_mask_intc
  import cpu_mask_intc_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int NUM_CPUS  = 2,
  parameter int ADDR_W    = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_WORDS*32-1:0] irqSrc,
  input  logic                    regWrEn,
  input  logic                    regRdEn,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [31:0]             regWrData,
  output logic [31:0]             regRdData,
  output logic [NUM_CPUS-1:0]     cpuIrq
);
  ctrlStrobe_t strobe;

  cpu_mask_intc_ctrl #(
    .NUM_WORDS(NUM_WORDS), .NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W)
  ) ctrl_i (
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .strobe(strobe)
  );

  cpu_mask_intc_dp #(
    .NUM_WORDS(NUM_WORDS), .NUM_CPUS(NUM_CPUS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .irqSrc(irqSrc),
    .regWrData(regWrData), .regRdData(regRdData), .cpuIrq(cpuIrq)
  );
endmodule

// File: rtl/cpu_mask_intc_chk.sv
module cpu_mask_intc_chk #(
  parameter int NUM_WORDS = 2,
  parameter int NUM_CPUS  = 2,
  parameter int ADDR_W    = 12
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [NUM_WORDS*32-1:0] irqSrc,
  input logic                    regRdEn,
  input logic [ADDR_W-1:0]       regAddr,
  input logic [31:0]             regRdData,
  input logic [NUM_CPUS-1:0]     cpuIrq
);
  localparam int OFS_W = $clog2(16 * NUM_WORDS);
  localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;

  int          offIdx;
  int          cpuIdx;
  logic        okAddr;
  logic        isStatus;
  logic        isMaskRd;
  logic [31:0] srcWord;

  always_comb begin
    offIdx  = int'(regAddr[OFS_W-1:2]);
    cpuIdx  = int'(regAddr[OFS_W +: CPU_W]);
    okAddr  = (regAddr[1:0] == 2'b00) && ((regAddr >> (OFS_W + CPU_W)) == '0)
              && (cpuIdx < NUM_CPUS) && (offIdx < 4 * NUM_WORDS);
    isStatus = okAddr && (offIdx < NUM_WORDS);
    isMaskRd = okAddr && (offIdx >= NUM_WORDS) && (offIdx < 2 * NUM_WORDS);
    srcWord  = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (isStatus && offIdx == w) srcWord = irqSrc[w*32 +: 32];
  end

  AST_IRQ_QUIET_NO_SRC: assert property (@(posedge clk) disable iff (!rstN)
    (irqSrc == '0) |=> (cpuIrq == '0)); // R8

  AST_STATUS_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && isStatus) |=> (regRdData == $past(srcWord))); // R5

  AST_SETCLR_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && okAddr && !isStatus && !isMaskRd) |=> (regRdData == '0)); // R6

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !okAddr) |=> (regRdData == '0)); // R10

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> $stable(regRdData)); // R11
endmodule

bind cpu_mask_intc cpu_mask_intc_chk #(
  .NUM_WORDS(NUM_WORDS), .NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rstN(rstN), .irqSrc(irqSrc), .regRdEn(regRdEn),
  .regAddr(regAddr), .regRdData(regRdData), .cpuIrq(cpuIrq)
);

// File: tb/cpu_mask_intc_tb_top.sv
module cpu_mask_intc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 3;
  localparam int NC = 2;
  localparam int AW = 12;
  localparam int OFS = 6;   // clog2(16*NW)

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NW*32-1:0] irqSrc = '0;
  logic           regWrEn = 1'b0;
  logic           regRdEn = 1'b0;
  logic [AW-1:0]  regAddr = '0;
  logic [31:0]    regWrData = '0;
  logic [31:0]    regRdData;
  logic [NC-1:0]  cpuIrq;

  int checks = 0;
  int failures = 0;
  logic [31:0] mdlMask [NC][NW];

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_mask_intc #(.NUM_WORDS(NW), .NUM_CPUS(NC), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .irqSrc(irqSrc), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .cpuIrq(cpuIrq)
  );

  function automatic logic [AW-1:0] addrOf(int cpu, int g, int w);
    return AW'((cpu << OFS) | ((g * NW + w) * 4));
  endfunction

  // Decode per R2/R10: returns -1 when out of range
  function automatic int decIdx(logic [AW-1:0] a, output int cpu);
    cpu = int'(a[OFS]);
    if (a[1:0] != 2'b00) return -1;
    if ((a >> (OFS + 1)) != '0) return -1;
    if (int'(a[OFS-1:2]) >= 4 * NW) return -1;
    return int'(a[OFS-1:2]);
  endfunction

  function automatic logic [31:0] expRead(logic [AW-1:0] a);
    int cpu;
    int idx;
    idx = decIdx(a, cpu);
    if (idx < 0) return '0;
    if (idx / NW == 0) return irqSrc[(idx % NW)*32 +: 32];
    if (idx / NW == 1) return mdlMask[cpu][idx % NW];
    return '0;
  endfunction

  function automatic logic [NC-1:0] expIrq();
    logic [NC-1:0] r;
    r = '0;
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++)
        if ((irqSrc[w*32 +: 32] & ~mdlMask[c][w]) != 0) r[c] = 1'b1;
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [AW-1:0] a, logic [31:0] d);
    int cpu;
    int idx;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    idx = decIdx(a, cpu);
    if (idx >= 0 && idx / NW == 2) mdlMask[cpu][idx % NW] |= d;
    if (idx >= 0 && idx / NW == 3) mdlMask[cpu][idx % NW] &= ~d;
  endtask

  task automatic busRead(string req, logic [AW-1:0] a);
    logic [31:0] e;
    regRdEn = 1'b1; regAddr = a;
    e = expRead(a);
    @(negedge clk);
    regRdEn = 1'b0;
    chk(req, regRdData, e);
  endtask

  task automatic checkIrq(string req);
    @(negedge clk);
    chk(req, 32'(cpuIrq), 32'(expIrq()));
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240517));
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) mdlMask[c][w] = '1;
    irqSrc = {32'h8000_0001, 32'h0000_ff00, 32'h1234_5678};
    repeat (3) @(negedge clk);
    chk("R1 cpuIrq in reset", 32'(cpuIrq), 0);
    chk("R1 rdata in reset", regRdData, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 cpuIrq after reset", 32'(cpuIrq), 0);
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) begin
        busRead("R1 mask all ones", addrOf(c, 1, w));
        chk("R1 mask model", mdlMask[c][w], 32'hffff_ffff);
      end

    // R5 status live, not cleared
    busRead("R5 status w0", addrOf(0, 0, 0));
    busRead("R5 status w0 again", addrOf(0, 0, 0));
    busRead("R5 status w2 cpu1", addrOf(1, 0, 2));

    // R4 clear, R2 layout, R9 independence, R8 line
    busWrite(addrOf(0, 3, 1), 32'h0000_0f00);
    busRead("R4 clear partial", addrOf(0, 1, 1));
    chk("R4 value", regRdData, 32'hffff_f0ff);
    busRead("R9 other bank untouched", addrOf(1, 1, 1));
    checkIrq("R8 cpu0 raised");
    chk("R9 cpu1 quiet", 32'(cpuIrq[1]), 0);
    busWrite(addrOf(1, 3, 2), 32'h8000_0000);
    busRead("R2 group1 word2 cpu1", addrOf(1, 1, 2));
    checkIrq("R8 cpu1 raised");

    // R3 set partial
    busWrite(addrOf(0, 2, 1), 32'h0000_0300);
    busRead("R3 set partial", addrOf(0, 1, 1));
    chk("R3 value", regRdData, 32'hffff_f3ff);

    // R6 set/clear read zero
    busRead("R6 set reads zero", addrOf(0, 2, 1));
    busRead("R6 clear reads zero", addrOf(1, 3, 0));

    // R7 writes ignored
    busWrite(addrOf(0, 1, 1), 32'h0);
    busWrite(addrOf(0, 0, 1), 32'hffff_ffff);
    busRead("R7 mask unchanged", addrOf(0, 1, 1));
    busRead("R7 status unchanged", addrOf(0, 0, 1));

    // R10 out of range
    busWrite(AW'(12 * 4), 32'hffff_ffff);
    busWrite(AW'((2 << OFS) | 12), 32'hffff_ffff);
    busWrite(addrOf(0, 3, 0) | AW'(1 << 8), 32'hffff_ffff);
    busWrite(addrOf(0, 3, 0) | AW'(2), 32'hffff_ffff);
    busRead("R10 mask kept after oor writes", addrOf(0, 1, 0));
    chk("R10 value", regRdData, 32'hffff_ffff);
    busRead("R10 offset past bank", AW'(13 * 4));
    busRead("R10 cpu index", AW'((3 << OFS) | 4));
    busRead("R10 misaligned", addrOf(0, 0, 0) | AW'(1));
    busRead("R10 upper bit", addrOf(0, 0, 0) | AW'(1 << 10));

    // R11 hold
    busRead("R11 load", addrOf(0, 0, 2));
    held = regRdData;
    irqSrc = '0;
    repeat (3) @(negedge clk);
    chk("R11 held", regRdData, held);
    checkIrq("R8 all quiet");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [AW-1:0] a;
      op = int'($urandom_range(0, 3));
      a = AW'($urandom_range(0, 255));
      if ($urandom_range(0, 3) != 0) a[1:0] = 2'b00;
      case (op)
        0: busWrite(a, $urandom() & $urandom());
        1: begin
          for (int w = 0; w < NW; w++)
            irqSrc[w*32 +: 32] = $urandom() & $urandom() & $urandom();
          checkIrq("R8 random src");
        end
        2: busRead("R6 R10 random read", a);
        default: checkIrq("R9 random line");
      endcase
    end
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) busRead("R3 R4 final mask", addrOf(c, 1, w));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule